// File: doc/BRIEF.md
# Dual Down-Counting Timer with Register Access

The block contains two identical 24-bit timers behind a plain 32-bit register bus. The bus has a write strobe, a read strobe, a word address and a data path in each direction. Software programs a reload value, a control word and a clock prescale for each timer. It then reads the live count, which falls by one on every prescaled tick. Inverting that value gives a rising time base.

When a timer's count is zero and a tick arrives, the timer has expired. In periodic mode it reloads from its reload register. In free-running mode it wraps to the all-ones value. Either way it latches a sticky event flag. The flag drives that timer's own interrupt line for as long as the timer is enabled. Software drops the flag by writing to the timer's acknowledge offset.

Top module: `rtim_top`

## Requirements
- R1: After reset every register of both timers reads as zero and both interrupt lines are low.
- R2: Timer i occupies byte offsets i*0x20 to i*0x20+0xC. Reload is at +0x0, live count at +0x4, control at +0x8 and acknowledge at +0xC. Reads of +0x10 to +0x1C return zero. Read data appears on the cycle after the read strobe.
- R3: A write to the reload offset stores the low 24 bits. On the same edge the live count takes that value. Reading the reload offset returns it zero-extended to 32 bits.
- R4: Control bit 7 is enable, bit 6 is periodic and bits 3:2 are the prescale code. Every other control bit reads as zero.
- R5: Prescale code 00 gives one tick per clock, 01 one tick every 16 clocks, and both 10 and 11 one tick every 256 clocks. The prescaler restarts whenever the timer is disabled. The first tick after enabling comes one full prescale interval later.
- R6: While enabled, the count falls by one per tick. While disabled it holds its value. Reading the count offset returns the live value zero-extended.
- R7: In periodic mode, a tick at count zero reloads the count from the reload register. The interrupt therefore rises div*(reload+1) clocks after enabling.
- R8: In free-running mode, a tick at count zero wraps the count to 0xFFFFFF.
- R9: Expiry sets a sticky flag. A timer's interrupt line equals flag AND enable. It is registered and changes on the same edge as the flag or the enable bit.
- R10: Any write to the acknowledge offset clears the flag; an expiry on the same edge takes priority. Reads of the acknowledge offset return zero.
- R11: The two timers are independent. Accesses and expiries of one never change the registers or the interrupt line of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address, byte-address bits 5:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 2 | Level interrupt, one per timer |

## Verification
The checker holds several rules on every cycle:
- an interrupt line is never high while its timer is disabled;
- a disabled timer's count never moves unless its reload offset is written;
- clearing the enable bit drops the interrupt on the next edge;
- reads of the acknowledge offset return zero;
- reads of the count or control offsets never return bits outside their fields.

Only the bench scenarios can show the timing and reload behaviour. That covers the tick interval of each prescale code, the restart of the prescaler after a disable, and reload versus wrap at expiry. It also covers the sticky flag surviving a disable and re-enable, and the isolation between the two timers.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int EN_BIT      = 7;
  localparam int PERIODIC_BIT = 6;
  localparam int PSC_LSB     = 2;
  localparam int PSC_W       = 2;
  localparam int TIMER_LSB   = 5;

  typedef enum logic [2:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ACK    = 3'd3
  } rtim_reg_e;

  typedef struct packed {
    logic             en;
    logic             periodic;
    logic [PSC_W-1:0] psc;
  } rtim_ctrl_t;
endpackage

// File: rtl/rtim_prescaler.sv
module rtim_prescaler
  import rtim_pkg::*;
#(
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int PRE_W = SHIFT_HI;
  localparam logic [PRE_W-1:0] MASK_MID = PRE_W'((1 << SHIFT_MID) - 1);
  localparam logic [PRE_W-1:0] MASK_HI  = PRE_W'((1 << SHIFT_HI) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    unique case (code)
      2'b00:   mask = '0;
      2'b01:   mask = MASK_MID;
      default: mask = MASK_HI;
    endcase
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rtim_channel.sv
module rtim_channel
  import rtim_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int DATA_W    = 32,
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic              wr_ack,
  input  logic [CNT_W-1:0]  wval,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic              en_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  rtim_ctrl_t       ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] reload_q, count_q, count_nxt;
  logic             flag_q, flag_nxt, irq_q;
  logic             tick, expire;

  rtim_prescaler #(.SHIFT_MID(SHIFT_MID), .SHIFT_HI(SHIFT_HI)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (ctrl_q.en),
    .code(ctrl_q.psc),
    .tick(tick)
  );

  assign expire = tick && (count_q == '0);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt.en       = wval[EN_BIT];
      ctrl_nxt.periodic = wval[PERIODIC_BIT];
      ctrl_nxt.psc      = wval[PSC_LSB +: PSC_W];
    end
    if (wr_reload)   count_nxt = wval;
    else if (expire) count_nxt = ctrl_q.periodic ? reload_q : ALL_ONES;
    else if (tick)   count_nxt = count_q - 1'b1;
    else             count_nxt = count_q;
    if (expire)      flag_nxt = 1'b1;
    else if (wr_ack) flag_nxt = 1'b0;
    else             flag_nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      count_q  <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      if (wr_reload) reload_q <= wval;
      count_q <= count_nxt;
      flag_q  <= flag_nxt;
      irq_q   <= flag_nxt && ctrl_nxt.en;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[EN_BIT]              = ctrl_q.en;
    ctrl_rd_o[PERIODIC_BIT]        = ctrl_q.periodic;
    ctrl_rd_o[PSC_LSB +: PSC_W]    = ctrl_q.psc;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign en_o     = ctrl_q.en;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rtim_top.sv
module rtim_top
  import rtim_pkg::*;
#(
  parameter int N_TIMERS  = 2,
  parameter int CNT_W     = 24,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:2]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [N_TIMERS-1:0] irq
);
  localparam int SEL_W = ADDR_W - TIMER_LSB;

  logic [SEL_W-1:0]          sel_idx;
  logic [2:0]                reg_sel;
  logic [CNT_W-1:0]          reload_v [N_TIMERS];
  logic [CNT_W-1:0]          count_v  [N_TIMERS];
  logic [DATA_W-1:0]         ctrl_v   [N_TIMERS];
  logic [N_TIMERS*CNT_W-1:0] cnt_flat;
  logic [N_TIMERS-1:0]       en_vec;
  logic [DATA_W-1:0]         rd_nxt;
  logic                      unused_wdata_hi;

  assign sel_idx = bus_addr[ADDR_W-1:TIMER_LSB];
  assign reg_sel = bus_addr[TIMER_LSB-1:2];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    logic hit;
    assign hit = (sel_idx == SEL_W'(i));

    rtim_channel #(
      .CNT_W(CNT_W), .DATA_W(DATA_W),
      .SHIFT_MID(SHIFT_MID), .SHIFT_HI(SHIFT_HI)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_reload(bus_wr && hit && reg_sel == REG_RELOAD),
      .wr_ctrl  (bus_wr && hit && reg_sel == REG_CTRL),
      .wr_ack   (bus_wr && hit && reg_sel == REG_ACK),
      .wval     (bus_wdata[CNT_W-1:0]),
      .reload_o (reload_v[i]),
      .count_o  (count_v[i]),
      .ctrl_rd_o(ctrl_v[i]),
      .en_o     (en_vec[i]),
      .irq_o    (irq[i])
    );
    assign cnt_flat[i*CNT_W +: CNT_W] = count_v[i];
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (sel_idx == SEL_W'(i)) begin
        case (reg_sel)
          REG_RELOAD: rd_nxt = DATA_W'(reload_v[i]);
          REG_COUNT:  rd_nxt = DATA_W'(count_v[i]);
          REG_CTRL:   rd_nxt = ctrl_v[i];
          default:    rd_nxt = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/rtim_checker.sv
module rtim_checker #(
  parameter int N_TIMERS = 2,
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [ADDR_W-1:2]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [N_TIMERS-1:0]       irq,
  input logic [N_TIMERS-1:0]       en_vec,
  input logic [N_TIMERS*CNT_W-1:0] cnt_flat
);
  localparam int SEL_W = ADDR_W - 5;
  localparam logic [DATA_W-1:0] CTRL_FIELDS = DATA_W'(32'hCC);

  logic [2:0] off;
  assign off = bus_addr[4:2];

  // R10
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 3'd3) |=> (bus_rdata == '0));

  // R6
  count_width_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 3'd1) |=> (bus_rdata[DATA_W-1:CNT_W] == '0));

  // R4
  ctrl_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 3'd2) |=> ((bus_rdata & ~CTRL_FIELDS) == '0));

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    logic hit;
    assign hit = (bus_addr[ADDR_W-1:5] == SEL_W'(i));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> en_vec[i]);

    // R9
    disable_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && hit && off == 3'd2 && !bus_wdata[7]) |=> !irq[i]);

    // R6
    idle_count_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[i] && !(bus_wr && hit && off == 3'd0))
        |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
  end
endmodule

bind rtim_top rtim_checker #(
  .N_TIMERS(N_TIMERS), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .en_vec   (en_vec),
  .cnt_flat (cnt_flat)
);

// File: tb/rtim_top_test.sv
module rtim_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rtim_top uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [5:2] ad(input int t, input int off);
    logic [5:0] b;
    b = 6'(t * 32 + off);
    return b[5:2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad(t, off); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int t, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ad(t, off);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int t, input int limit, output int n);
    n = 0;
    while (!irq[t] && n < limit) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'h0);
    for (int t = 0; t < 2; t++)
      for (int o = 0; o < 16; o += 4) begin
        rd(t, o, d);
        check("R1 register", d, 32'h0);
      end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(0, 0, 32'hAB12_3456);
    rd(0, 0, d); check("R3 reload readback", d, 32'h0012_3456);
    rd(0, 4, d); check("R3 count follows reload", d, 32'h0012_3456);
    wr(0, 8, 32'hFFFF_FF7F);
    rd(0, 8, d); check("R4 control fields", d, 32'h0000_004C);
    rd(1, 0, d); check("R11 other reload untouched", d, 32'h0);
    rd(1, 8, d); check("R11 other control untouched", d, 32'h0);
    rd(0, 16, d); check("R2 unmapped offset", d, 32'h0);
    rd(0, 12, d); check("R10 ack reads zero", d, 32'h0);
    wr(0, 8, 32'h0);
  endtask

  task automatic t_countdown();
    logic [31:0] a, b;
    wr(0, 0, 32'd100);
    wr(0, 8, 32'h80);
    rd(0, 4, a); rd(0, 4, b);
    check("R6 first count", a, 32'd100);
    check("R6 one tick later", b, 32'd99);
    wr(0, 8, 32'h0);
    rd(0, 4, a); repeat (5) @(posedge clk); rd(0, 4, b);
    check("R6 disabled count holds", b, a);
  endtask

  task automatic t_periodic_div1();
    int n; logic [31:0] d;
    wr(0, 12, 32'h0);
    wr(0, 0, 32'd3);
    wr(0, 8, 32'hC0);
    wait_irq(0, 1000, n);
    check("R7 R5 div1 expiry interval", 32'(n), 32'd4);
    check("R11 other irq quiet", 32'(irq[1]), 32'h0);
    rd(0, 4, d); check("R7 reload at expiry", d, 32'd3);
    wr(0, 8, 32'h0);
    check("R9 disable drops irq", 32'(irq[0]), 32'h0);
    wr(0, 12, 32'h0);
  endtask

  task automatic t_free();
    int n; logic [31:0] d;
    wr(1, 12, 32'h0);
    wr(1, 0, 32'd0);
    wr(1, 8, 32'h84);
    wait_irq(1, 1000, n);
    check("R5 div16 interval", 32'(n), 32'd16);
    rd(1, 4, d); check("R8 wrap to all ones", d, 32'h00FF_FFFF);
    check("R9 flag sticky", 32'(irq[1]), 32'h1);
    wr(1, 8, 32'h0);
    check("R9 irq gated by enable", 32'(irq[1]), 32'h0);
    wr(1, 8, 32'h84);
    check("R9 flag survives disable", 32'(irq[1]), 32'h1);
    wr(1, 12, 32'h0);
    check("R10 ack clears irq", 32'(irq[1]), 32'h0);
    wr(1, 8, 32'h0);
  endtask

  task automatic t_reserved();
    int n;
    wr(0, 12, 32'h0);
    wr(0, 0, 32'd0);
    wr(0, 8, 32'hCC);
    wait_irq(0, 2000, n);
    check("R5 code 11 acts as div256", 32'(n), 32'd256);
    wr(0, 8, 32'h0);
    wr(0, 12, 32'h0);
  endtask

  task automatic t_periodic_div256();
    int n; logic [31:0] d;
    wr(1, 12, 32'h0);
    wr(1, 0, 32'd1);
    wr(1, 8, 32'hC8);
    wait_irq(1, 2000, n);
    check("R5 R7 div256 interval", 32'(n), 32'd512);
    rd(1, 4, d); check("R7 periodic reload", d, 32'd1);
    check("R11 other irq quiet", 32'(irq[0]), 32'h0);
    wr(1, 8, 32'h0);
    wr(1, 12, 32'h0);
  endtask

  task automatic t_restart();
    int n;
    wr(0, 12, 32'h0);
    wr(0, 0, 32'd0);
    wr(0, 8, 32'hC4);
    repeat (10) @(posedge clk);
    wr(0, 8, 32'h0);
    wr(0, 8, 32'hC4);
    wait_irq(0, 1000, n);
    check("R5 prescaler restarts on disable", 32'(n), 32'd16);
    wr(0, 8, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_regs();
    t_countdown();
    t_periodic_div1();
    t_free();
    t_reserved();
    t_periodic_div256();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule